// File: doc/BRIEF.md
# Counter-Compare Watchdog Timer

This block is a watchdog built around a free-running 16-bit up-counter and an 8-bit compare register. A prescaler advances the counter once every 12, 4 or 1 system clocks. The watchdog raises a reset request when the counter's low byte wraps from 0xFF to 0x00 while the high byte equals the compare register. The timeout is therefore counted in low-byte wraps, and the first interval after a restart depends on where the low byte stood at that moment.

Software keeps the system alive by writing the compare register. Each such write loads the compare register with the current counter high byte plus a programmable 8-bit offset, so the next match lies the chosen number of wraps ahead. A lock bit keeps the watchdog enabled until the next reset. An idle-suspend option freezes counting while the CPU is idle. Software can also force an immediate reset request.

Access is through a register write port and a combinational read port. The block comes out of reset armed, with the shortest timeout.

Top module: `cmp_watchdog`

## Requirements
- R1: After reset the watchdog is enabled, unlocked, not idle-suspended and set to divide by 12. The offset, compare value and counter are all zero, so the control register reads 0x01.
- R2: With the reset configuration left untouched, the first request pulse follows the 3074th rising clock edge after rst_n rises. This is 256 counter steps of 12 clocks each, plus two clocks for reset synchronisation.
- R3: A request is raised only when three conditions hold together: the counter low byte wraps, the high byte equals the compare value, and the watchdog is enabled. The request lasts one system clock.
- R4: Writing address 2 loads the compare register with (counter high byte + offset) mod 256. The next request then comes 256*offset + 256 - L counter steps later, where L is the low byte just before the write.
- R5: Writing address 3 with bit 0 set while the watchdog is enabled raises a request on the next clock. When the watchdog is disabled, that write has no effect.
- R6: The watchdog is enabled when control bit 0 (enable) or bit 1 (lock) is 1. Lock can only be set, and stays set until reset. Clearing enable while unlocked disables the watchdog.
- R7: While the watchdog is enabled, writes to the clock-select field (control bits 5:3) and the idle-suspend bit (control bit 2) are ignored.
- R8: Clock-select 1 advances the counter every 4 clocks and 2 advances it every clock. Select 0 and all other codes advance it every 12 clocks.
- R9: When idle-suspend is set and cpu_idle is high, the counter holds its value. Otherwise cpu_idle has no effect.
- R10: Writing the offset (address 1) does not change the compare register. The new offset is used only at the next compare write.
- R11: The read map is: 0 = control, 1 = offset, 2 = compare, 3 = counter low, 4 = counter high, all others 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| cpu_idle | input | 1 | CPU idle indication |
| wdt_rst_req | output | 1 | One-clock reset request |

## Verification
A corrupted prescaler or counter appears as a wrong timeout length. It can be seen within one counter step on the counter-low read port, and as a shifted request edge on the default 3074-clock timeout. A wrong compare value or a wrong offset sum shows directly on the compare readback. It also moves the request by a whole multiple of 256 counter steps, which the restart test measures to the exact clock. A lock or configuration-freeze fault appears on the control readback one clock after the offending write.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
  typedef struct packed {
    logic [2:0] clk_sel;
    logic       idle_sus;
    logic       lock;
    logic       en;
  } cwd_ctrl_t;

  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_OFFS  = 3'd1;
  localparam logic [2:0] ADR_CMP   = 3'd2;
  localparam logic [2:0] ADR_FLAG  = 3'd3;
  localparam logic [2:0] ADR_CNTHI = 3'd4;

  localparam logic [2:0] SEL_DIV4 = 3'd1;
  localparam logic [2:0] SEL_DIV1 = 3'd2;
endpackage

// File: rtl/cwd_prescaler.sv
module cwd_prescaler #(
  parameter int DIV_SLOW = 12,
  parameter int DIV_MID  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  import cwd_pkg::*;
  localparam int PW = $clog2(DIV_SLOW);

  logic [PW-1:0] pre_q, pre_d, lim;

  always_comb begin
    case (sel)
      SEL_DIV4: lim = PW'(DIV_MID - 1);
      SEL_DIV1: lim = '0;
      default:  lim = PW'(DIV_SLOW - 1);
    endcase
  end

  assign tick = run && (pre_q >= lim);

  always_comb begin
    pre_d = pre_q;
    if (run) pre_d = tick ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R8: the fastest selection steps on every running clock
  p_div1_every_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sel == SEL_DIV1 && $past(run) && $past(sel) == SEL_DIV1) |-> tick);
endmodule

// File: rtl/cwd_counter.sv
module cwd_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             lo_wrap
);
  localparam int HW = CNT_W / 2;

  logic [CNT_W-1:0] cnt_d;

  assign lo_wrap = tick && (cnt[HW-1:0] == {HW{1'b1}});

  always_comb begin
    cnt_d = cnt;
    if (tick) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R3: a low-byte wrap leaves the low byte at zero
  p_wrap_lands_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wrap |=> (cnt[HW-1:0] == '0));
endmodule

// File: rtl/cwd_regs.sv
module cwd_regs #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [CNT_W/2-1:0] wr_data,
  input  logic [2:0]         rd_addr,
  input  logic [CNT_W-1:0]   cnt,
  output logic [CNT_W/2-1:0] rd_data,
  output logic [CNT_W/2-1:0] cmp,
  output logic [2:0]         clk_sel,
  output logic               idle_sus,
  output logic               wd_on,
  output logic               force_req
);
  import cwd_pkg::*;
  localparam int DW = CNT_W / 2;

  cwd_ctrl_t     ctrl_q, ctrl_d;
  logic [DW-1:0] offs_q, offs_d, cmp_d;

  assign wd_on    = ctrl_q.en | ctrl_q.lock;
  assign clk_sel  = ctrl_q.clk_sel;
  assign idle_sus = ctrl_q.idle_sus;
  assign force_req = wr_en && (wr_addr == ADR_FLAG) && wr_data[0] && wd_on;

  always_comb begin
    ctrl_d = ctrl_q;
    offs_d = offs_q;
    cmp_d  = cmp;
    if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: begin
          ctrl_d.en   = wr_data[0];
          ctrl_d.lock = ctrl_q.lock | wr_data[1];
          if (!wd_on) begin
            ctrl_d.idle_sus = wr_data[2];
            ctrl_d.clk_sel  = wr_data[5:3];
          end
        end
        ADR_OFFS: offs_d = wr_data;
        ADR_CMP:  cmp_d  = cnt[CNT_W-1:DW] + offs_q;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{clk_sel: 3'd0, idle_sus: 1'b0, lock: 1'b0, en: 1'b1};
      offs_q <= '0;
      cmp    <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      offs_q <= offs_d;
      cmp    <= cmp_d;
    end
  end

  always_comb begin
    case (rd_addr)
      ADR_CTRL:  rd_data = DW'(ctrl_q);
      ADR_OFFS:  rd_data = offs_q;
      ADR_CMP:   rd_data = cmp;
      ADR_FLAG:  rd_data = cnt[DW-1:0];
      ADR_CNTHI: rd_data = cnt[CNT_W-1:DW];
      default:   rd_data = '0;
    endcase
  end

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.lock |=> ctrl_q.lock);
  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_on |=> ($stable(ctrl_q.clk_sel) && $stable(ctrl_q.idle_sus)));
  p_cmp_only_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADR_CMP) |=> $stable(cmp));
endmodule

// File: rtl/cmp_watchdog.sv
module cmp_watchdog #(
  parameter int CNT_W    = 16,
  parameter int DIV_SLOW = 12,
  parameter int DIV_MID  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       cpu_idle,
  output logic       wdt_rst_req
);
  localparam int DW = CNT_W / 2;

  logic [1:0]       rst_sync;
  logic             rst_i_n;
  logic             tick, lo_wrap, run, wd_on, idle_sus, force_req;
  logic             expire, req_d;
  logic [2:0]       clk_sel;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  assign run = !(idle_sus && cpu_idle);

  cwd_prescaler #(.DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID)) u_pre (
    .clk(clk), .rst_n(rst_i_n), .run(run), .sel(clk_sel), .tick(tick));

  cwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .cnt(cnt), .lo_wrap(lo_wrap));

  cwd_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .cnt(cnt), .rd_data(rd_data),
    .cmp(cmp), .clk_sel(clk_sel), .idle_sus(idle_sus), .wd_on(wd_on),
    .force_req(force_req));

  assign expire = wd_on && lo_wrap && (cnt[CNT_W-1:DW] == cmp);

  always_comb begin
    req_d = expire | force_req;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) wdt_rst_req <= 1'b0;
    else          wdt_rst_req <= req_d;
  end

  p_req_needs_on_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    wdt_rst_req |-> $past(wd_on));
  p_match_fires_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (lo_wrap && wd_on && cnt[CNT_W-1:DW] == cmp) |=> wdt_rst_req);
  p_off_silent_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    !wd_on |=> !wdt_rst_req);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (idle_sus && cpu_idle) |=> $stable(cnt));
endmodule

// File: tb/cmp_watchdog_tb.sv
module cmp_watchdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {wr_addr[21:19], wr_data[18:11], rd_addr[10:8], expected[7:0]}
  localparam logic [21:0] VEC [NVEC] = '{
    {3'd0, 8'h00, 3'd0, 8'h00},  // R6 disable
    {3'd0, 8'h08, 3'd0, 8'h08},  // R7 sel taken while off
    {3'd0, 8'h04, 3'd0, 8'h04},  // R7 idle taken while off
    {3'd1, 8'h05, 3'd1, 8'h05},  // R11 offset readback
    {3'd0, 8'h01, 3'd0, 8'h01},  // R6 enable
    {3'd0, 8'h3D, 3'd0, 8'h01},  // R7 sel/idle ignored while on
    {3'd1, 8'h07, 3'd2, 8'h00},  // R10 compare untouched
    {3'd0, 8'h00, 3'd0, 8'h00}   // R6 disable again
  };

  logic clk = 1'b0;
  logic rst_n, wr_en, cpu_idle;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic wdt_rst_req;
  int n_cmp = 0, n_bad = 0;

  cmp_watchdog dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cpu_idle(cpu_idle),
    .wdt_rst_req(wdt_rst_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int settle);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; cpu_idle = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (settle) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic rate(input string tag, input int cycles, input int exp);
    logic [7:0] a, b;
    repeat (16) @(negedge clk);
    rd(3'd3, a);
    repeat (cycles) @(negedge clk);
    rd(3'd3, b);
    chk(tag, int'(8'(b - a)), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, lo, hi;
    int k;
    bit got;

    // R1 / R11: reset state
    do_reset(3);
    rd(3'd0, v); chk("R1 ctrl", v, 8'h01);
    rd(3'd1, v); chk("R1 offset", v, 8'h00);
    rd(3'd2, v); chk("R1 compare", v, 8'h00);
    rd(3'd4, v); chk("R1 cnt hi", v, 8'h00);
    rd(3'd6, v); chk("R11 unmapped", v, 8'h00);

    // R2 / R3: default timeout, one-clock pulse
    @(negedge clk); rst_n = 1'b0; repeat (2) @(negedge clk);
    rst_n = 1'b1;
    k = 0; got = 0;
    while (!got && k < 4000) begin
      @(posedge clk); k++; #1;
      if (wdt_rst_req) got = 1;
    end
    chk("R2 default timeout edge", k, 3074);
    @(posedge clk); #1;
    chk("R3 pulse width", wdt_rst_req, 0);

    // Table walk: R6 R7 R10 R11
    do_reset(3);
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][21:19], VEC[i][18:11]);
      rd(VEC[i][10:8], v);
      chk($sformatf("R6/R7/R10 vector %0d", i), v, VEC[i][7:0]);
    end

    // R3: disabled watchdog never times out
    do_reset(3);
    wr(3'd0, 8'h00);
    got = 0;
    repeat (3300) begin @(negedge clk); if (wdt_rst_req) got = 1; end
    chk("R3 disabled no expiry", got, 0);

    // R4 / R8: restart with offset 2 at divide-by-1
    do_reset(3);
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h10);
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h11);
    rd(3'd3, lo); rd(3'd4, hi);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h00;
    k = 0; got = 0;
    while (!got && k < 2000) begin
      @(posedge clk); k++;
      @(negedge clk); wr_en = 1'b0;
      if (wdt_rst_req) got = 1;
    end
    chk("R4 restart timeout", k, 768 - int'(lo));
    rd(3'd2, v); chk("R4 compare = hi+offset", v, int'(8'(hi + 8'd2)));

    // R5: forced request
    do_reset(3);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h01;
    @(posedge clk); #1;
    chk("R5 force while on", wdt_rst_req, 1);
    @(negedge clk); wr_en = 1'b0;
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h01);
    chk("R5 force while off", wdt_rst_req, 0);

    // R6: lock
    do_reset(3);
    wr(3'd0, 8'h02);
    wr(3'd0, 8'h00);
    rd(3'd0, v); chk("R6 lock sticky", v, 8'h02);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h01;
    @(posedge clk); #1;
    chk("R6 locked stays on", wdt_rst_req, 1);
    @(negedge clk); wr_en = 1'b0;

    // R8: rates
    do_reset(3);
    wr(3'd0, 8'h00);
    rate("R8 div12", 48, 4);
    wr(3'd0, 8'h08); rate("R8 div4", 40, 10);
    wr(3'd0, 8'h10); rate("R8 div1", 40, 40);
    wr(3'd0, 8'h28); rate("R8 code5 div12", 48, 4);

    // R9: idle suspend
    wr(3'd0, 8'h14);
    cpu_idle = 1'b1; rate("R9 idle hold", 20, 0);
    cpu_idle = 1'b0; rate("R9 idle released", 20, 20);
    wr(3'd0, 8'h10);
    cpu_idle = 1'b1; rate("R9 idle ignored", 20, 20);
    cpu_idle = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule